// File: doc/BRIEF.md
# Two-Wire Controller Probe Stub

This block takes the place of a two-wire serial controller in a system where no real sensors are fitted, yet firmware still probes for them at startup. It exposes a 32-bit word-wide register bus with separate read and write strobes. The block drives no bus wires. It only answers register accesses so that the probing code sees the success it expects.

Three completion-event offsets always read back as set. One receive-data offset replays a fixed, scripted series of bytes, one entry per read. Once the series runs out, the final byte repeats. Every other offset acts as plain read/write storage, indexed by the byte address divided by four. A reset clears all storage and rewinds the script.

Top module: `tw_probe_stub`

## Requirements
- R1: While reset is asserted and directly after it, `bus_rdata` is 0, every storage word reads as 0, and the script pointer is back at its first entry. A reset in the middle of the script also rewinds it.
- R2: A read of offset 0x104, 0x108 or 0x11C returns 0x00000001. This holds even after any value has been written to that offset.
- R3: After reset, successive reads of offset 0x518 return 0x0000005A, then 0x0000005A, then 0x00000040. The byte sits in bits 7:0 and all upper bits are 0.
- R4: After the third receive read, every further read of 0x518 returns 0x00000040 and the pointer stays on that entry.
- R5: A read of any other word-aligned offset in the 4 KB window returns the last value written there, or 0 if nothing has been written since reset. Each word is stored at index address/4.
- R6: Read data appears on `bus_rdata` in the clock cycle after the edge that samples `bus_rd`. It holds its value in every cycle that has no read.
- R7: The script pointer advances only on reads of 0x518. Reads of other offsets, and writes to any offset including 0x518, leave the next receive byte unchanged.
- R8: When a read and a write hit the same word on the same edge, the read returns the value the word held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (12) | Byte address of the access, word aligned |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |

## Verification
The bench builds the block with its default parameters:
- a 12-bit address, which gives a 1024-word storage window;
- three event offsets;
- a three-entry script.

With these values the top word at 0xFFC can be reached, and the script runs to its saturating tail after only three receive reads. Every word-aligned offset the bench touches therefore falls into exactly one of three read sources. The bench switches between them in back-to-back cycles and checks each result against its own reference model.

// File: rtl/tw_stub_pkg.sv
package tw_stub_pkg;
   typedef enum logic [1:0] {
      SRC_STORE = 2'd0,
      SRC_EVENT = 2'd1,
      SRC_RX    = 2'd2
   } rd_src_e;
endpackage

// File: rtl/tw_addr_decode.sv
module tw_addr_decode
   import tw_stub_pkg::*;
#(
   parameter int ADDR_W  = 12,
   parameter int NUM_EVT = 3,
   parameter logic [NUM_EVT*ADDR_W-1:0] EVT_OFFS = {12'h11C, 12'h108, 12'h104},
   parameter logic [ADDR_W-1:0] RX_OFF = 12'h518
) (
   input  logic [ADDR_W-1:0] addr,
   output rd_src_e           src,
   output logic [ADDR_W-3:0] widx
);
   logic [NUM_EVT-1:0] evt_match;

   for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
      localparam logic [ADDR_W-1:0] OFF = EVT_OFFS[e*ADDR_W +: ADDR_W];
      if (OFF[1:0] != 2'b00) begin : g_bad_align
         $error("event offset %0d is not word aligned", e);
      end
      if (OFF == RX_OFF) begin : g_bad_clash
         $error("event offset %0d collides with receive offset", e);
      end
      assign evt_match[e] = (addr == OFF);
   end

   if (RX_OFF[1:0] != 2'b00) begin : g_bad_rx
      $error("receive offset is not word aligned");
   end

   always_comb begin
      if (|evt_match)          src = SRC_EVENT;
      else if (addr == RX_OFF) src = SRC_RX;
      else                     src = SRC_STORE;
   end

   assign widx = addr[ADDR_W-1:2];
endmodule

// File: rtl/tw_seq_replay.sv
module tw_seq_replay #(
   parameter int SEQ_LEN = 3,
   parameter int BYTE_W  = 8,
   parameter logic [SEQ_LEN*BYTE_W-1:0] SEQ_BYTES = {8'h40, 8'h5A, 8'h5A}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   output logic [BYTE_W-1:0] byte_o
);
   localparam int PTR_W = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;
   localparam logic [PTR_W-1:0] LAST = PTR_W'(SEQ_LEN - 1);

   if (SEQ_LEN < 1) begin : g_bad_len
      $error("script needs at least one entry");
   end

   logic [PTR_W-1:0] ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     ptr_q <= '0;
      else if (adv && ptr_q != LAST)  ptr_q <= ptr_q + 1'b1;
   end

   always_comb begin
      byte_o = '0;
      for (int i = 0; i < SEQ_LEN; i++) begin
         if (ptr_q == PTR_W'(i)) byte_o = SEQ_BYTES[i*BYTE_W +: BYTE_W];
      end
   end

   AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_q <= LAST);                                              // R4
   AST_PTR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(ptr_q));                                    // R7
   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && ptr_q != LAST) |=> ptr_q == $past(ptr_q) + 1'b1);    // R3
endmodule

// File: rtl/tw_word_store.sv
module tw_word_store #(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  widx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int WORDS = 2 ** IDX_W;

   logic [DATA_W-1:0] mem [WORDS];

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          mem[w] <= '0;
         else if (we && widx == IDX_W'(w))    mem[w] <= wdata;
      end
   end

   assign rdata = mem[widx];
endmodule

// File: rtl/tw_probe_stub.sv
module tw_probe_stub
   import tw_stub_pkg::*;
#(
   parameter int ADDR_W  = 12,
   parameter int DATA_W  = 32,
   parameter int BYTE_W  = 8,
   parameter int NUM_EVT = 3,
   parameter logic [NUM_EVT*ADDR_W-1:0] EVT_OFFS = {12'h11C, 12'h108, 12'h104},
   parameter logic [ADDR_W-1:0] RX_OFF = 12'h518,
   parameter int SEQ_LEN = 3,
   parameter logic [SEQ_LEN*BYTE_W-1:0] SEQ_BYTES = {8'h40, 8'h5A, 8'h5A},
   parameter logic [DATA_W-1:0] EVT_VAL = 32'h1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata
);
   localparam int IDX_W = ADDR_W - 2;

   if (ADDR_W < 3) begin : g_bad_addr
      $error("address must span more than one word");
   end
   if (DATA_W <= BYTE_W) begin : g_bad_data
      $error("data word must be wider than a script byte");
   end

   rd_src_e           src;
   logic [IDX_W-1:0]  widx;
   logic [DATA_W-1:0] store_rd;
   logic [BYTE_W-1:0] rx_byte;
   logic              rx_adv;

   tw_addr_decode #(
      .ADDR_W(ADDR_W), .NUM_EVT(NUM_EVT), .EVT_OFFS(EVT_OFFS), .RX_OFF(RX_OFF)
   ) u_dec (
      .addr(bus_addr), .src(src), .widx(widx)
   );

   tw_word_store #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
      .clk(clk), .rst_n(rst_n), .we(bus_wr), .widx(widx),
      .wdata(bus_wdata), .rdata(store_rd)
   );

   assign rx_adv = bus_rd && (src == SRC_RX);

   tw_seq_replay #(
      .SEQ_LEN(SEQ_LEN), .BYTE_W(BYTE_W), .SEQ_BYTES(SEQ_BYTES)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .adv(rx_adv), .byte_o(rx_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (bus_rd) begin
         unique case (src)
            SRC_EVENT: bus_rdata <= EVT_VAL;
            SRC_RX:    bus_rdata <= DATA_W'(rx_byte);
            default:   bus_rdata <= store_rd;
         endcase
      end
   end

   AST_EVT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && src == SRC_EVENT) |=> bus_rdata == EVT_VAL);          // R2
   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));                                 // R6
   AST_RX_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && src == SRC_RX) |=> bus_rdata[DATA_W-1:BYTE_W] == '0); // R3
endmodule

// File: tb/tw_probe_stub_test.sv
`timescale 1ns/1ps
module tw_probe_stub_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   // reference model state
   logic [31:0] ref_mem [int];
   logic [31:0] ref_rdata = '0;
   int          ref_ptr = 0;
   logic [31:0] script [3] = '{32'h5A, 32'h5A, 32'h40};

   always #4 clk = ~clk;

   tw_probe_stub uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
   );

   task automatic compare(string req);
      checks++;
      if (bus_rdata !== ref_rdata) begin
         fails++;
         $display("FAIL %s: rdata actual %h expected %h", req, bus_rdata, ref_rdata);
      end
   endtask

   function automatic logic [31:0] ref_word(int idx);
      return ref_mem.exists(idx) ? ref_mem[idx] : 32'h0;
   endfunction

   // one bus cycle: drive, step model at the edge, compare after it
   task automatic op(bit rd, bit wr, logic [11:0] a, logic [31:0] d, string req);
      int idx;
      idx = int'(a) / 4;
      bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      if (rd) begin
         if (a == 12'h104 || a == 12'h108 || a == 12'h11C) ref_rdata = 32'h1;
         else if (a == 12'h518) begin
            ref_rdata = script[ref_ptr];
            if (ref_ptr < 2) ref_ptr++;
         end else ref_rdata = ref_word(idx);
      end
      if (wr) ref_mem[idx] = d;
      #2;
      compare(req);
      bus_rd = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic do_reset(string req);
      rst_n = 1'b0;
      @(posedge clk);
      #2;
      ref_mem.delete();
      ref_rdata = '0;
      ref_ptr = 0;
      compare(req);
      rst_n = 1'b1;
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      #1;
      do_reset("R1 reset state");
      // R1: fresh storage reads zero
      op(1, 0, 12'h000, 0, "R1 storage zero");
      op(1, 0, 12'hFFC, 0, "R1 storage zero top");
      // R3 script then R4 tail
      op(1, 0, 12'h518, 0, "R3 first byte");
      op(0, 0, 12'h000, 0, "R6 hold");
      op(1, 0, 12'h518, 0, "R3 second byte");
      op(1, 0, 12'h518, 0, "R3 third byte");
      for (int i = 0; i < 3; i++) op(1, 0, 12'h518, 0, "R4 tail repeat");
      // R2: events after writes
      op(0, 1, 12'h104, 32'h0, "R2 write stopped");
      op(0, 1, 12'h108, 32'hDEADBEEF, "R2 write rxready");
      op(0, 1, 12'h11C, 32'h0, "R2 write txsent");
      op(1, 0, 12'h104, 0, "R2 stopped reads 1");
      op(1, 0, 12'h108, 0, "R2 rxready reads 1");
      op(1, 0, 12'h11C, 0, "R2 txsent reads 1");
      // R5 plain storage
      op(0, 1, 12'h000, 32'h12345678, "R5 write 0");
      op(0, 1, 12'hFFC, 32'hA5A5F00F, "R5 write top");
      op(0, 1, 12'h100, 32'hCAFEF00D, "R5 write 100");
      op(1, 0, 12'h000, 0, "R5 read 0");
      op(1, 0, 12'h100, 0, "R5 read 100");
      op(1, 0, 12'hFFC, 0, "R5 read top");
      op(0, 1, 12'h100, 32'h00000000, "R5 overwrite");
      op(1, 0, 12'h100, 0, "R5 read overwrite");
      for (int i = 0; i < 4; i++) op(0, 0, 12'h000, 0, "R6 idle hold");
      // R8 read and write same word same edge
      op(1, 1, 12'h000, 32'h0BADC0DE, "R8 old value");
      op(1, 0, 12'h000, 0, "R8 new value");
      // R1 reset mid-script, R7 non-rx traffic leaves pointer alone
      do_reset("R1 mid reset");
      op(1, 0, 12'h518, 0, "R1 rewound");
      op(0, 1, 12'h518, 32'h77, "R7 write rx");
      op(1, 0, 12'h104, 0, "R7 other read");
      op(1, 0, 12'h200, 0, "R7 storage read");
      op(1, 0, 12'h518, 0, "R7 second byte kept");
      op(1, 0, 12'h518, 0, "R7 third byte");
      op(1, 0, 12'h518, 0, "R4 saturated");
      for (int i = 0; i < 16; i++)
         op(1, 1, 12'(16 * i), 32'(i * 7 + 1), "R5 sweep");
      for (int i = 0; i < 16; i++)
         op(1, 0, 12'(16 * i), 0, "R5 sweep read");
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule